// File: doc/BRIEF.md
# Host Register Bus Slave with Alarm Interrupt

This block lets an external microprocessor reach the control and alarm registers of a line-interface device. Two strap inputs pick one of four bus personalities. The first strap chooses between a multiplexed 8-bit address/data bus and a separate 4-bit address bus with an 8-bit data bus. The second strap chooses the strobe set: either separate active-low read and write strobes, or one active-low data strobe with a read/write level. Every host pin is sampled on the system clock. A ready/acknowledge output adds zero to three wait states and is enabled only while an access to this device is in progress.

In the multiplexed modes the host puts an address byte on the bus and drops an address-latch strobe. The upper nibble of that byte must equal a device number held in the configuration register, which lets several devices share one bus. In the separate-address modes an external active-low chip select does the same job. Alarm inputs pass through rising-edge detectors into sticky status bits. A read of the status register clears the bits it returned. A registered, active-high interrupt is raised while any enabled status bit is set.

The access engine has four states. ST_IDLE waits for a strobe while the device is selected. It moves to ST_WAIT when wait states are configured and to ST_XFER when they are not. ST_WAIT counts down and moves to ST_XFER when its count expires, or returns to ST_IDLE if the strobe is withdrawn. ST_XFER performs the register read or write and raises ready. It then moves to ST_HOLD if the strobe is still present, or back to ST_IDLE. ST_HOLD keeps ready (and read data) on the bus until the strobe is released, then returns to ST_IDLE.

Top module: `hbi_host_if`

## Requirements
- R1: With `mux_mode`=1, the register address is the `ad_i` byte sampled when `ale` falls. An access is served only when bits [7:4] of that byte equal the device number in configuration bits [7:4]. Bits [3:0] give the register. `cs_n` and `addr_i` are ignored. A non-matching access gets no ready, no data and makes no write.
- R2: With `mux_mode`=0, the register is taken from `addr_i` and the device is selected by `cs_n`=0. With `cs_n`=1 there is no response and no write, and `ale` has no effect.
- R3: With `strobe_mode`=0, `rdn_dsn`=0 reads and `wrn_rw`=0 writes. With `strobe_mode`=1, `rdn_dsn`=0 is the data strobe and `wrn_rw` gives the direction (1 read, 0 write). In that mode `wrn_rw` alone starts nothing.
- R4: Once an access starts, `rdy_o` is low for exactly N cycles, where N is configuration bits [1:0]. It is then high, and it stays high until the strobe is released.
- R5: `rdy_oe` is 0 whenever no access to this device is in progress, including the cycle after the strobe is released.
- R6: Register map: 0 = alarm status (read clears), 1 = interrupt enable mask (read/write), 2 = configuration (read/write), 3 = current alarm levels (read only), all other addresses read 0. Read data is on `ad_o` with `ad_oe`=1 only while `rdy_o` is high.
- R7: A rising edge on an alarm input sets its status bit. An alarm held high sets the bit only once per activation.
- R8: A status read clears exactly the bits it returned. An alarm edge in the same cycle as the read stays set and appears on the next read.
- R9: `irq` is high when any status bit whose mask bit is 1 is set, and it lags the status by one clock. A masked alarm never raises `irq` but can still be read.
- R10: After the host reads the status register, `irq` deasserts unless a new enabled edge has arrived.
- R11: After reset, mask, configuration and status are 0, and `irq`, `rdy_oe` and `ad_oe` are 0.
- R12: Writes to the status, alarm-level and unused addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_mode | input | 1 | Strap: 1 multiplexed address/data, 0 separate address bus |
| strobe_mode | input | 1 | Strap: 0 read/write strobes, 1 data strobe with direction level |
| ale | input | 1 | Address-latch strobe, multiplexed modes |
| cs_n | input | 1 | Active-low chip select, separate-address modes |
| addr_i | input | 4 | Register address, separate-address modes |
| rdn_dsn | input | 1 | Read strobe or data strobe, active low |
| wrn_rw | input | 1 | Write strobe (active low) or direction level (1 read) |
| ad_i | input | 8 | Bus data (and address byte in multiplexed modes) into the block |
| ad_o | output | 8 | Read data out of the block |
| ad_oe | output | 1 | Enable for the `ad_o` drivers |
| rdy_o | output | 1 | Ready/acknowledge level |
| rdy_oe | output | 1 | Enable for the `rdy_o` driver |
| alarm_i | input | 8 | Alarm source levels |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach is an alarm edge that lands in the same clock cycle the status read samples its data. Reaching it requires the host strobe and the alarm input to change at the same clock edge. The bench's access task can therefore raise a chosen alarm pattern on the same half-cycle that it asserts the strobe, with no wait states configured. The test then checks that the first read returns only the older bit and that the second read returns the bit that arrived during the first read. The multiplexed modes need a device-number write before any matching access can succeed. The bench therefore reprograms the device number over the bus, confirms that accesses to the old number go unanswered, and then restores it.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_HOLD
    } acc_state_e;

    localparam int REG_STAT = 0;
    localparam int REG_MASK = 1;
    localparam int REG_CFG  = 2;
    localparam int REG_LIVE = 3;
endpackage

// File: rtl/hbi_bus_decode.sv
module hbi_bus_decode #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int IDW = DW - AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mux_mode,
    input  logic           strobe_mode,
    input  logic           ale,
    input  logic           cs_n,
    input  logic [AW-1:0]  addr_i,
    input  logic           rdn_dsn,
    input  logic           wrn_rw,
    input  logic [DW-1:0]  ad_i,
    input  logic [IDW-1:0] dev_id_i,
    output logic           active_o,
    output logic           is_read_o,
    output logic           sel_o,
    output logic [AW-1:0]  reg_addr_o
);
    logic          ale_q;
    logic [DW-1:0] addr_lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q      <= 1'b0;
            addr_lat_q <= '0;
        end else begin
            ale_q <= ale;
            if (mux_mode && ale_q && !ale)
                addr_lat_q <= ad_i;
        end
    end

    always_comb begin
        unique case (strobe_mode)
            1'b0: begin
                active_o  = !rdn_dsn || !wrn_rw;
                is_read_o = !rdn_dsn;
            end
            1'b1: begin
                active_o  = !rdn_dsn;
                is_read_o = wrn_rw;
            end
            default: begin
                active_o  = 1'b0;
                is_read_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (mux_mode) begin
            sel_o      = (addr_lat_q[DW-1:AW] == dev_id_i);
            reg_addr_o = addr_lat_q[AW-1:0];
        end else begin
            sel_o      = !cs_n;
            reg_addr_o = addr_i;
        end
    end
endmodule

// File: rtl/hbi_access_fsm.sv
module hbi_access_fsm
    import hbi_pkg::*;
#(
    parameter int AW  = 4,
    parameter int WCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active_i,
    input  logic           is_read_i,
    input  logic           sel_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [WCW-1:0] wait_cfg_i,
    output logic           fire_o,
    output logic           acc_read_o,
    output logic [AW-1:0]  acc_addr_o,
    output logic           rdy_o,
    output logic           rdy_oe_o,
    output logic           data_oe_o
);
    acc_state_e     state_q, state_d;
    logic [WCW-1:0] cnt_q, cnt_d;
    logic           read_q;
    logic [AW-1:0]  addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            read_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE) begin
                read_q <= is_read_i;
                addr_q <= addr_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active_i && sel_i) begin
                    if (wait_cfg_i != '0) begin
                        state_d = ST_WAIT;
                        cnt_d   = wait_cfg_i;
                    end else begin
                        state_d = ST_XFER;
                    end
                end
            end
            ST_WAIT: begin
                if (!active_i)
                    state_d = ST_IDLE;
                else if (cnt_q == WCW'(1))
                    state_d = ST_XFER;
                else
                    cnt_d = cnt_q - WCW'(1);
            end
            ST_XFER: state_d = active_i ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!active_i)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fire_o     = (state_d == ST_XFER) && (state_q != ST_XFER);
        acc_read_o = (state_q == ST_IDLE) ? is_read_i : read_q;
        acc_addr_o = (state_q == ST_IDLE) ? addr_i : addr_q;
        rdy_o      = (state_q == ST_XFER) || (state_q == ST_HOLD);
        rdy_oe_o   = (state_q != ST_IDLE);
        data_oe_o  = rdy_o && read_q;
    end

    // R4: ready stays up while the strobe is held
    a_r4_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && active_i) |=> rdy_o);
    // R4: the wait counter never exceeds the configured count
    a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt_q != '0 && cnt_q <= wait_cfg_i));
    // R5: releasing the strobe ends the access on the next edge
    a_r5_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i) |=> !rdy_oe_o);
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile
    import hbi_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int NA  = 8,
    parameter int WCW = 2,
    localparam int IDW = DW - AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire_i,
    input  logic           op_read_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [NA-1:0]  stat_i,
    input  logic [NA-1:0]  live_i,
    output logic [DW-1:0]  rdata_o,
    output logic [NA-1:0]  mask_o,
    output logic [WCW-1:0] wait_cfg_o,
    output logic [IDW-1:0] dev_id_o,
    output logic           stat_clr_o
);
    logic [NA-1:0] mask_q;
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            AW'(REG_STAT): rd_mux[NA-1:0] = stat_i;
            AW'(REG_MASK): rd_mux[NA-1:0] = mask_q;
            AW'(REG_CFG):  rd_mux         = cfg_q;
            AW'(REG_LIVE): rd_mux[NA-1:0] = live_i;
            default:       rd_mux         = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cfg_q   <= '0;
            rdata_q <= '0;
        end else if (fire_i) begin
            if (op_read_i) begin
                rdata_q <= rd_mux;
            end else if (addr_i == AW'(REG_MASK)) begin
                mask_q <= wdata_i[NA-1:0];
            end else if (addr_i == AW'(REG_CFG)) begin
                cfg_q <= wdata_i;
            end
        end
    end

    assign stat_clr_o = fire_i && op_read_i && (addr_i == AW'(REG_STAT));
    assign rdata_o    = rdata_q;
    assign mask_o     = mask_q;
    assign wait_cfg_o = cfg_q[WCW-1:0];
    assign dev_id_o   = cfg_q[DW-1:AW];

    // R12: a write elsewhere leaves the mask untouched
    a_r12_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !op_read_i && addr_i != AW'(REG_MASK)) |=> $stable(mask_q));
endmodule

// File: rtl/hbi_alarm.sv
module hbi_alarm #(
    parameter int NA = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NA-1:0] alarm_i,
    input  logic [NA-1:0] mask_i,
    input  logic          clr_i,
    output logic [NA-1:0] stat_o,
    output logic [NA-1:0] live_o,
    output logic          irq_o
);
    logic [NA-1:0] alarm_q;
    logic [NA-1:0] stat_q;
    logic [NA-1:0] rise;
    logic          irq_q;

    for (genvar i = 0; i < NA; i++) begin : g_edge
        assign rise[i] = alarm_i[i] && !alarm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            stat_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            alarm_q <= alarm_i;
            stat_q  <= (clr_i ? '0 : stat_q) | rise;
            irq_q   <= |(stat_q & mask_i);
        end
    end

    assign stat_o = stat_q;
    assign live_o = alarm_q;
    assign irq_o  = irq_q;

    // R8: an edge is never lost, even during a clearing read
    a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(rise)) == $past(rise)));
    // R7: without a clearing read, set bits stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (($past(stat_q) & ~stat_q) == '0));
    // R9: a fully masked status cannot raise the interrupt
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !irq_q);
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if #(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int NA  = 8,
    parameter int WCW = 2,
    localparam int IDW = DW - AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          strobe_mode,
    input  logic          ale,
    input  logic          cs_n,
    input  logic [AW-1:0] addr_i,
    input  logic          rdn_dsn,
    input  logic          wrn_rw,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          rdy_o,
    output logic          rdy_oe,
    input  logic [NA-1:0] alarm_i,
    output logic          irq
);
    logic           active, is_read, sel;
    logic [AW-1:0]  reg_addr, acc_addr;
    logic           fire, acc_read;
    logic [WCW-1:0] wait_cfg;
    logic [IDW-1:0] dev_id;
    logic [NA-1:0]  mask, stat, live;
    logic           stat_clr;

    hbi_bus_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .strobe_mode(strobe_mode),
        .ale(ale), .cs_n(cs_n), .addr_i(addr_i), .rdn_dsn(rdn_dsn), .wrn_rw(wrn_rw),
        .ad_i(ad_i), .dev_id_i(dev_id), .active_o(active), .is_read_o(is_read),
        .sel_o(sel), .reg_addr_o(reg_addr)
    );

    hbi_access_fsm #(.AW(AW), .WCW(WCW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active_i(active), .is_read_i(is_read),
        .sel_i(sel), .addr_i(reg_addr), .wait_cfg_i(wait_cfg), .fire_o(fire),
        .acc_read_o(acc_read), .acc_addr_o(acc_addr), .rdy_o(rdy_o),
        .rdy_oe_o(rdy_oe), .data_oe_o(ad_oe)
    );

    hbi_regfile #(.AW(AW), .DW(DW), .NA(NA), .WCW(WCW)) u_regs (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .op_read_i(acc_read),
        .addr_i(acc_addr), .wdata_i(ad_i), .stat_i(stat), .live_i(live),
        .rdata_o(ad_o), .mask_o(mask), .wait_cfg_o(wait_cfg), .dev_id_o(dev_id),
        .stat_clr_o(stat_clr)
    );

    hbi_alarm #(.NA(NA)) u_alarm (
        .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .mask_i(mask),
        .clr_i(stat_clr), .stat_o(stat), .live_o(live), .irq_o(irq)
    );

    // R6: data drivers only open while ready is driven high
    a_r6_data_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (rdy_o && rdy_oe));
    // R5: ready level is meaningful only while its driver is enabled
    a_r5_ready_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> rdy_oe);
endmodule

// File: tb/tb_hbi_host_if.sv
module tb_hbi_host_if;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_mode = 1'b0, strobe_mode = 1'b0, ale = 1'b0, cs_n = 1'b1;
    logic [3:0] addr_i = '0;
    logic       rdn_dsn = 1'b1, wrn_rw = 1'b1;
    logic [7:0] ad_i = '0, alarm_i = '0;
    logic [7:0] ad_o;
    logic       ad_oe, rdy_o, rdy_oe, irq;

    int checks = 0, errors = 0;
    bit done = 0;
    bit cs_en = 1;
    int extra_hold = 0;
    bit inj_en = 0;
    logic [7:0] inj_val = '0;
    int last_waits;
    bit last_resp;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbi_host_if dut (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .strobe_mode(strobe_mode),
        .ale(ale), .cs_n(cs_n), .addr_i(addr_i), .rdn_dsn(rdn_dsn), .wrn_rw(wrn_rw),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
        .alarm_i(alarm_i), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected value per read that presents data
    always @(negedge clk) begin
        logic [7:0] e;
        string t;
        if (ad_oe && rdy_o) begin
            if (!seen) begin
                seen = 1;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected read data actual %0h expected none", ad_o);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (ad_o !== e) begin
                        errors++;
                        $display("FAIL %s read data actual %0h expected %0h", t, ad_o, e);
                    end
                end
            end
        end else begin
            seen = 0;
        end
    end

    task automatic access(input bit rd, input logic [7:0] addr, input logic [7:0] wdata);
        last_waits = 0;
        last_resp  = 0;
        if (mux_mode) begin
            @(negedge clk); ale = 1'b1; ad_i = addr;
            @(negedge clk); ale = 1'b0;
            @(negedge clk); ad_i = wdata;
        end else begin
            @(negedge clk); addr_i = addr[3:0]; ad_i = wdata; cs_n = !cs_en;
        end
        if (strobe_mode) begin
            wrn_rw = rd; rdn_dsn = 1'b0;
        end else if (rd) rdn_dsn = 1'b0;
        else wrn_rw = 1'b0;
        if (inj_en) alarm_i = inj_val;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rdy_oe && rdy_o) begin
                last_resp = 1;
                break;
            end
            if (rdy_oe) last_waits++;
        end
        if (last_resp) begin
            for (int k = 0; k < extra_hold; k++) begin
                @(negedge clk);
                chk(rdy_o && rdy_oe, "R4 ready held", rdy_o, 1);
            end
        end
        rdn_dsn = 1'b1; wrn_rw = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!rdy_oe && !ad_oe, "R5 idle after release", rdy_oe, 0);
    endtask

    task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1, addr, 8'h00);
        chk(last_resp, {tag, " read answered"}, last_resp, 1);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        access(0, addr, data);
        chk(last_resp, "R6 write answered", last_resp, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!irq && !rdy_oe && !ad_oe, "R11 outputs at reset", {irq, rdy_oe, ad_oe}, 0);
        rd(8'h01, 8'h00, "R11 mask");
        rd(8'h02, 8'h00, "R11 cfg");
        rd(8'h00, 8'h00, "R11 status");

        // R6 register map
        wr(8'h01, 8'hA5);
        rd(8'h01, 8'hA5, "R6 mask");
        rd(8'h03, 8'h00, "R6 live");
        rd(8'h09, 8'h00, "R6 unused");

        // R12 writes to read-only / unused addresses
        wr(8'h00, 8'hFF);
        rd(8'h00, 8'h00, "R12 status");
        wr(8'h07, 8'h55);
        rd(8'h07, 8'h00, "R12 unused");
        wr(8'h03, 8'h77);
        rd(8'h01, 8'hA5, "R12 mask kept");
        rd(8'h02, 8'h00, "R12 cfg kept");

        // R2 chip select and ALE ignored in separate-address mode
        cs_en = 0;
        access(0, 8'h01, 8'h00);
        chk(!last_resp, "R2 no response without select", last_resp, 0);
        cs_en = 1;
        @(negedge clk); ale = 1'b1; ad_i = 8'hF2;
        @(negedge clk); ale = 1'b0;
        rd(8'h01, 8'hA5, "R2 ale ignored");

        // R4 wait states 0..3 with held strobe
        extra_hold = 2;
        for (int n = 0; n < 4; n++) begin
            wr(8'h02, 8'(n));
            rd(8'h01, 8'hA5, "R4 data with waits");
            chk(last_waits == n, "R4 wait count", last_waits, n);
        end
        extra_hold = 0;
        wr(8'h02, 8'h00);

        // R3 data strobe with direction level
        strobe_mode = 1'b1;
        wr(8'h01, 8'h3C);
        rd(8'h01, 8'h3C, "R3 ds read");
        @(negedge clk); cs_n = 1'b0; addr_i = 4'h1; wrn_rw = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rdy_oe, "R3 direction alone idle", rdy_oe, 0);
        cs_n = 1'b1; wrn_rw = 1'b1;
        strobe_mode = 1'b0;

        // R1 multiplexed mode with device number
        mux_mode = 1'b1;
        wr(8'h02, 8'h50);
        rd(8'h51, 8'h3C, "R1 matching id");
        access(1, 8'h01, 8'h00);
        chk(!last_resp, "R1 old id ignored", last_resp, 0);
        access(0, 8'h01, 8'hFF);
        chk(!last_resp, "R1 foreign write ignored", last_resp, 0);
        strobe_mode = 1'b1;
        rd(8'h51, 8'h3C, "R1 mask kept ds");
        strobe_mode = 1'b0;
        wr(8'h52, 8'h00);
        mux_mode = 1'b0;
        rd(8'h02, 8'h00, "R1 id restored");

        // R7 R9 R10 alarms
        wr(8'h01, 8'h05);
        @(negedge clk); alarm_i = 8'h01;
        @(negedge clk);
        @(negedge clk);
        chk(irq, "R9 irq on enabled alarm", irq, 1);
        rd(8'h00, 8'h01, "R7 status set");
        chk(!irq, "R10 irq cleared by read", irq, 0);
        repeat (3) @(negedge clk);
        rd(8'h00, 8'h00, "R7 held alarm once");
        chk(!irq, "R7 no repeat irq", irq, 0);
        @(negedge clk); alarm_i = 8'h00;
        @(negedge clk); alarm_i = 8'h01;
        @(negedge clk);
        rd(8'h00, 8'h01, "R7 new activation");
        @(negedge clk); alarm_i = 8'h03;
        repeat (3) @(negedge clk);
        chk(!irq, "R9 masked alarm quiet", irq, 1'b0);
        rd(8'h00, 8'h02, "R9 masked alarm polled");
        rd(8'h03, 8'h03, "R6 live levels");

        // R8 edge during the clearing read
        @(negedge clk); alarm_i = 8'h00;
        @(negedge clk); alarm_i = 8'h04;
        repeat (2) @(negedge clk);
        inj_en = 1; inj_val = 8'h0C;
        rd(8'h00, 8'h04, "R8 read returns old bits");
        inj_en = 0;
        chk(!irq, "R10 irq drops, new bit masked", irq, 0);
        rd(8'h00, 8'h08, "R8 same-cycle edge kept");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads observed", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule